// File: doc/BRIEF.md
# Wired-OR Bus Master Transfer Engine

This block lets local user logic become a master on a simple shared on-chip bus. On that bus every master output is OR-combined with the outputs of the other masters, and a central arbiter hands out the bus. The user gives one command: a start address, a direction and a length in words. For writes, the user also supplies one data word at a time. The engine then requests the bus and waits for a grant. It runs each word transfer with select, address and data, and ends each transfer when the slave or the bus answers.

A transfer can end in one of four ways. An acknowledge completes the word. A retry makes the engine give the bus back and repeat the same word. An error acknowledge or a timeout aborts the whole run. When a run has more than one word, the engine holds a bus lock so that the arbiter keeps the bus with it. The lock is dropped one word early, so that the final word runs unlocked. Every output toward the bus stays at zero whenever the engine is not using it. This keeps the engine from disturbing the OR-combined bus.

Top module: `wor_bus_master`

## Requirements
- R1: While reset is high and in the first cycle after it, bus_req, bus_sel, bus_lock, bus_rnw, bus_addr and bus_dout are all zero. cmd_ready is high, and rd_valid, usr_beat and done are low.
- R2: A command is taken only in a cycle where cmd_valid and cmd_ready are both high. bus_req rises in the next cycle. A cmd_valid pulse while cmd_ready is low has no effect on the running transfer, and no further transfer follows it.
- R3: When bus_grant is high while bus_req is high, bus_sel is high and bus_req is low in the next cycle. bus_req and bus_sel are never high together.
- R4: bus_sel stays high, with address and data unchanged, until a termination input is high. It is low in the cycle after that termination input.
- R5: Whenever bus_sel is low, bus_addr, bus_dout and bus_rnw are zero. While bus_sel is high, bus_rnw is 1 for a read and 0 for a write, and bus_dout is zero for a read.
- R6: The first transfer uses cmd_addr unchanged. Each acknowledged word moves the address up by DATA_W/8 bytes.
- R7: For a run of more than one word, bus_lock rises together with the first bus_sel. It falls in the cycle after the acknowledge of the second-to-last word. A one-word run never raises bus_lock.
- R8: On a read, the bus_din value present in the cycle where bus_ack is high appears on rd_data in the next cycle. rd_valid is high for exactly that one cycle.
- R9: On a write, each transfer drives the usr_wdata word presented when the grant is taken. usr_beat pulses for one cycle after every acknowledged word, for reads and writes. The user then presents the next word.
- R10: On bus_retry, in the next cycle bus_sel is low and bus_req is high. The same address and data word are then driven again, and the run continues.
- R11: bus_err or bus_tmo aborts the run. In the next cycle, done pulses with done_status 1 for an error or 2 for a timeout, bus_lock is low, and the engine is idle. When several termination inputs are high together, the priority is error, then timeout, then retry, then acknowledge.
- R12: After the acknowledge of the final word, done pulses with done_status 0 and cmd_ready returns high. A cmd_len of zero runs one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_ready | output | 1 | Engine idle, command accepted |
| cmd_write | input | 1 | 1 = write run, 0 = read run |
| cmd_addr | input | ADDR_W | Byte address of the first word |
| cmd_len | input | LEN_W | Number of words (0 counts as 1) |
| usr_wdata | input | DATA_W | Current write word from the user |
| usr_beat | output | 1 | Pulse after each acknowledged word |
| rd_data | output | DATA_W | Captured read word |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| done | output | 1 | One-cycle run-finished pulse |
| done_status | output | 2 | 0 ok, 1 error, 2 timeout |
| bus_req | output | 1 | Request to the arbiter |
| bus_grant | input | 1 | Grant from the arbiter |
| bus_sel | output | 1 | Master select |
| bus_lock | output | 1 | Keep-bus lock |
| bus_rnw | output | 1 | Read-not-write, zero when idle |
| bus_addr | output | ADDR_W | Address, zero when idle |
| bus_dout | output | DATA_W | Write data, zero when idle |
| bus_din | input | DATA_W | Read data from the bus |
| bus_ack | input | 1 | Transfer acknowledge |
| bus_err | input | 1 | Error acknowledge |
| bus_tmo | input | 1 | Bus timeout |
| bus_retry | input | 1 | Retry request |

## Verification
The bench builds the engine with its defaults: 32-bit address and data, an 8-bit length and the abort inputs enabled. With the abort inputs enabled, error, timeout and retry endings can be reached, along with their priority when they arrive together. The 4-byte step makes address arithmetic visible across runs of up to a dozen words. A reactive arbiter and a reactive slave model give random grant and acknowledge delays. This exposes lock release on the second-to-last word, address and data repetition after a retry, and the one-word case with a zero length.

// File: rtl/wbm_pkg.sv
package wbm_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_XFER = 2'd2
  } wbm_state_t;

  typedef enum logic [1:0] {
    ST_OK  = 2'd0,
    ST_ERR = 2'd1,
    ST_TMO = 2'd2
  } wbm_status_t;
endpackage

// File: rtl/wbm_walker.sv
// Address and remaining-word bookkeeping for one run.
module wbm_walker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              advance,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  len,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              on_last,
  output logic              on_penult
);
  localparam int STEP = DATA_W / 8;
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);
  localparam logic [LEN_W-1:0]  ONE    = LEN_W'(1);
  localparam logic [LEN_W-1:0]  TWO    = LEN_W'(2);

  logic [LEN_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      remain   <= '0;
    end else if (load) begin
      cur_addr <= start_addr;
      remain   <= (len == '0) ? ONE : len;
    end else if (advance) begin
      cur_addr <= cur_addr + STEP_V;
      remain   <= remain - ONE;
    end
  end

  assign on_last   = (remain == ONE);
  assign on_penult = (remain == TWO);
endmodule

// File: rtl/wbm_fsm.sv
// Arbitration handshake, select, lock and run sequencing.
module wbm_fsm
  import wbm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic       cmd_write,
  input  logic       grant,
  input  logic       t_ack_in,
  input  logic       t_err_in,
  input  logic       t_tmo_in,
  input  logic       t_rty_in,
  input  logic       on_last,
  input  logic       on_penult,
  output logic       cmd_ready,
  output logic       req,
  output logic       sel,
  output logic       lock,
  output logic       is_write,
  output logic       load,
  output logic       launch,
  output logic       advance,
  output logic       clear,
  output logic       ack_take,
  output logic       beat,
  output logic       done,
  output logic [1:0] status
);
  wbm_state_t st;
  logic in_xfer, t_err, t_tmo, t_rty, t_ack;

  always_comb begin
    in_xfer  = (st == S_XFER);
    t_err    = in_xfer && t_err_in;
    t_tmo    = in_xfer && t_tmo_in && !t_err_in;
    t_rty    = in_xfer && t_rty_in && !t_err_in && !t_tmo_in;
    t_ack    = in_xfer && t_ack_in && !t_err_in && !t_tmo_in && !t_rty_in;
    load     = (st == S_IDLE) && cmd_valid;
    launch   = (st == S_REQ) && grant;
    advance  = t_ack && !on_last;
    clear    = in_xfer && (t_ack_in || t_err_in || t_tmo_in || t_rty_in);
    ack_take = t_ack;
  end

  assign cmd_ready = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      req      <= 1'b0;
      sel      <= 1'b0;
      lock     <= 1'b0;
      is_write <= 1'b0;
      beat     <= 1'b0;
      done     <= 1'b0;
      status   <= ST_OK;
    end else begin
      beat <= 1'b0;
      done <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (cmd_valid) begin
            st       <= S_REQ;
            req      <= 1'b1;
            is_write <= cmd_write;
          end
        end
        S_REQ: begin
          if (grant) begin
            st  <= S_XFER;
            req <= 1'b0;
            sel <= 1'b1;
            if (!on_last) lock <= 1'b1;
          end
        end
        S_XFER: begin
          if (t_err || t_tmo) begin
            st     <= S_IDLE;
            sel    <= 1'b0;
            lock   <= 1'b0;
            done   <= 1'b1;
            status <= t_err ? ST_ERR : ST_TMO;
          end else if (t_rty) begin
            st  <= S_REQ;
            sel <= 1'b0;
            req <= 1'b1;
          end else if (t_ack) begin
            sel  <= 1'b0;
            beat <= 1'b1;
            if (on_last) begin
              st     <= S_IDLE;
              lock   <= 1'b0;
              done   <= 1'b1;
              status <= ST_OK;
            end else begin
              st  <= S_REQ;
              req <= 1'b1;
              if (on_penult) lock <= 1'b0;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wbm_lanes.sv
// Zero-gated address/data/direction lanes and read capture.
module wbm_lanes #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic              clear,
  input  logic              capture,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] din,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dout_o,
  output logic              rnw_o,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o   <= '0;
      dout_o   <= '0;
      rnw_o    <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (launch) begin
        addr_o <= cur_addr;
        dout_o <= is_write ? wdata : '0;
        rnw_o  <= !is_write;
      end else if (clear) begin
        addr_o <= '0;
        dout_o <= '0;
        rnw_o  <= 1'b0;
      end
      if (capture) begin
        rd_data  <= din;
        rd_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wor_bus_master.sv
module wor_bus_master #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 8,
  parameter bit HAS_ABORT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [DATA_W-1:0] usr_wdata,
  output logic              usr_beat,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              done,
  output logic [1:0]        done_status,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic              bus_sel,
  output logic              bus_lock,
  output logic              bus_rnw,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              bus_ack,
  input  logic              bus_err,
  input  logic              bus_tmo,
  input  logic              bus_retry
);
  logic err_m, tmo_m, rty_m;
  logic load, launch, advance, clear, ack_take, is_write;
  logic on_last, on_penult;
  logic [ADDR_W-1:0] cur_addr;

  generate
    if (HAS_ABORT) begin : g_abort
      assign err_m = bus_err;
      assign tmo_m = bus_tmo;
      assign rty_m = bus_retry;
    end else begin : g_no_abort
      assign err_m = 1'b0;
      assign tmo_m = 1'b0;
      assign rty_m = 1'b0;
    end
  endgenerate

  wbm_fsm u_fsm (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .grant(bus_grant),
    .t_ack_in(bus_ack), .t_err_in(err_m), .t_tmo_in(tmo_m), .t_rty_in(rty_m),
    .on_last(on_last), .on_penult(on_penult),
    .cmd_ready(cmd_ready), .req(bus_req), .sel(bus_sel), .lock(bus_lock),
    .is_write(is_write), .load(load), .launch(launch), .advance(advance),
    .clear(clear), .ack_take(ack_take), .beat(usr_beat), .done(done),
    .status(done_status)
  );

  wbm_walker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_walk (
    .clk(clk), .rst(rst), .load(load), .advance(advance),
    .start_addr(cmd_addr), .len(cmd_len),
    .cur_addr(cur_addr), .on_last(on_last), .on_penult(on_penult)
  );

  wbm_lanes #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lanes (
    .clk(clk), .rst(rst), .launch(launch), .clear(clear),
    .capture(ack_take && !is_write), .is_write(is_write),
    .cur_addr(cur_addr), .wdata(usr_wdata), .din(bus_din),
    .addr_o(bus_addr), .dout_o(bus_dout), .rnw_o(bus_rnw),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/wbm_checker.sv
module wbm_checker #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter bit HAS_ABORT = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              bus_req,
  input logic              bus_grant,
  input logic              bus_sel,
  input logic              bus_lock,
  input logic              bus_rnw,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_dout,
  input logic              bus_ack,
  input logic              bus_err,
  input logic              bus_tmo,
  input logic              bus_retry,
  input logic              done
);
  logic term;
  assign term = bus_ack || (HAS_ABORT && (bus_err || bus_tmo || bus_retry));

  p_req_start_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_ready && cmd_valid |=> bus_req);
  p_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && bus_sel));
  p_grant_r3: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_grant |=> bus_sel && !bus_req);
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    bus_sel && !term |=> bus_sel && $stable(bus_addr) && $stable(bus_dout));
  p_drop_r4: assert property (@(posedge clk) disable iff (rst)
    bus_sel && term |=> !bus_sel);
  p_zero_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !bus_sel |-> (bus_addr == '0) && (bus_dout == '0) && !bus_rnw);
  p_lock_busy_r7: assert property (@(posedge clk) disable iff (rst)
    bus_lock |-> !cmd_ready);
  p_done_idle_r12: assert property (@(posedge clk) disable iff (rst)
    done |-> cmd_ready && !bus_lock && !bus_req && !bus_sel);
endmodule

bind wor_bus_master wbm_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HAS_ABORT(HAS_ABORT)
) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .bus_req(bus_req), .bus_grant(bus_grant), .bus_sel(bus_sel),
  .bus_lock(bus_lock), .bus_rnw(bus_rnw), .bus_addr(bus_addr),
  .bus_dout(bus_dout), .bus_ack(bus_ack), .bus_err(bus_err),
  .bus_tmo(bus_tmo), .bus_retry(bus_retry), .done(done)
);

// File: tb/wor_bus_master_tb.sv
module wor_bus_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 0, cmd_write = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic [LW-1:0] cmd_len = '0;
  logic [DW-1:0] usr_wdata = '0, bus_din = '0;
  logic bus_grant = 0, bus_ack = 0, bus_err = 0, bus_tmo = 0, bus_retry = 0;
  logic cmd_ready, usr_beat, rd_valid, done, bus_req, bus_sel, bus_lock, bus_rnw;
  logic [1:0] done_status;
  logic [DW-1:0] rd_data, bus_dout;
  logic [AW-1:0] bus_addr;

  int total = 0, bad = 0, wd = 0;
  bit ended = 0;
  logic [DW-1:0] wwords [0:255];

  always #(CLK_PERIOD/2) clk = ~clk;

  wor_bus_master #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .HAS_ABORT(1'b1)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .usr_wdata(usr_wdata), .usr_beat(usr_beat), .rd_data(rd_data),
    .rd_valid(rd_valid), .done(done), .done_status(done_status),
    .bus_req(bus_req), .bus_grant(bus_grant), .bus_sel(bus_sel),
    .bus_lock(bus_lock), .bus_rnw(bus_rnw), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_din(bus_din), .bus_ack(bus_ack),
    .bus_err(bus_err), .bus_tmo(bus_tmo), .bus_retry(bus_retry)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] a0, input int k);
    return a0 + AW'(4 * k);
  endfunction

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !ended) begin
      ended = 1;
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=%0d", wd, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic idle_checks(input string tag);
    chk(bus_req == 0 && bus_sel == 0 && bus_lock == 0, tag, {bus_req, bus_sel, bus_lock}, 0);
    chk(bus_addr == 0 && bus_dout == 0 && bus_rnw == 0, tag, bus_addr | bus_dout, 0);
    chk(cmd_ready == 1, tag, cmd_ready, 1);
  endtask

  // combo: 0 random, 1 all four terminations at once, 2 timeout+retry+ack at once
  task automatic run(input bit wr, input logic [AW-1:0] a0, input logic [LW-1:0] len,
                     input int p_rty, input int p_err, input int p_tmo,
                     input bit poke, input int combo);
    int n, acked, cyc;
    bit granted, aborted, finished, exp_rv, exp_beat, exp_done, exp_rq;
    logic [1:0] exp_st;
    logic [DW-1:0] exp_rd;
    n = (len == 0) ? 1 : int'(len);
    for (int i = 0; i < n; i++) wwords[i] = $urandom;
    @(negedge clk);
    chk(cmd_ready == 1, "R2 ready before cmd", cmd_ready, 1);
    cmd_valid = 1; cmd_write = wr; cmd_addr = a0; cmd_len = len; usr_wdata = wwords[0];
    @(negedge clk);
    cmd_valid = 0;
    chk(bus_req == 1, "R2 request after cmd", bus_req, 1);
    acked = 0; cyc = 0; granted = 0; aborted = 0; finished = 0;
    exp_rv = 0; exp_beat = 0; exp_done = 0; exp_rq = 0; exp_st = 0; exp_rd = '0;
    while (!finished && cyc < 2000) begin
      if (cyc > 0) @(negedge clk);
      chk(!(bus_req && bus_sel), "R3 req/sel exclusive", {bus_req, bus_sel}, 0);
      if (!bus_sel)
        chk(bus_addr == 0 && bus_dout == 0 && bus_rnw == 0, "R5 idle lanes zero", bus_addr | bus_dout, 0);
      else begin
        chk(bus_addr == exp_addr(a0, acked), "R6 address", bus_addr, exp_addr(a0, acked));
        chk(bus_rnw == !wr, "R5 rnw", bus_rnw, !wr);
        chk(bus_dout == (wr ? wwords[acked] : '0), "R9 write data", bus_dout, wr ? wwords[acked] : '0);
      end
      chk(bus_lock == (granted && n > 1 && acked < n - 1 && !aborted), "R7 lock",
          bus_lock, granted && n > 1 && acked < n - 1 && !aborted);
      chk(rd_valid == exp_rv, "R8 rd_valid", rd_valid, exp_rv);
      if (exp_rv) chk(rd_data == exp_rd, "R8 rd_data", rd_data, exp_rd);
      chk(usr_beat == exp_beat, "R9 beat", usr_beat, exp_beat);
      chk(done == exp_done, aborted ? "R11 done" : "R12 done", done, exp_done);
      chk(cmd_ready == exp_done, "R2 busy", cmd_ready, exp_done);
      if (exp_rq) chk(bus_req == 1 && bus_sel == 0, "R10 re-request", {bus_req, bus_sel}, 2'b10);
      if (exp_done) begin
        chk(done_status == exp_st, aborted ? "R11 status" : "R12 status", done_status, exp_st);
        finished = 1;
      end
      exp_rv = 0; exp_beat = 0; exp_done = 0; exp_rq = 0;
      bus_grant = 0; bus_ack = 0; bus_err = 0; bus_tmo = 0; bus_retry = 0;
      usr_wdata = wwords[(acked < n) ? acked : 0];
      cmd_valid = 0;
      if (poke && cyc == 2) begin
        cmd_valid = 1; cmd_addr = 32'hDEAD_0000; cmd_write = !wr; cmd_len = 8'd9;
      end
      if (!finished) begin
        if (bus_req && ($urandom % 3 != 0)) begin
          bus_grant = 1; granted = 1;
        end else if (bus_sel && ($urandom % 4 != 0)) begin
          if (combo == 1) begin
            bus_err = 1; bus_tmo = 1; bus_retry = 1; bus_ack = 1;
            aborted = 1; exp_done = 1; exp_st = 2'd1;
          end else if (combo == 2) begin
            bus_tmo = 1; bus_retry = 1; bus_ack = 1;
            aborted = 1; exp_done = 1; exp_st = 2'd2;
          end else begin
            int r;
            r = int'($urandom % 100);
            if (r < p_err) begin
              bus_err = 1; aborted = 1; exp_done = 1; exp_st = 2'd1;
            end else if (r < p_err + p_tmo) begin
              bus_tmo = 1; aborted = 1; exp_done = 1; exp_st = 2'd2;
            end else if (r < p_err + p_tmo + p_rty) begin
              bus_retry = 1; exp_rq = 1;
            end else begin
              bus_ack = 1; bus_din = $urandom; exp_beat = 1;
              if (!wr) begin exp_rv = 1; exp_rd = bus_din; end
              acked++;
              if (acked == n) begin exp_done = 1; exp_st = 2'd0; end
            end
          end
        end
      end
      cyc++;
    end
    chk(finished, "R12 run finished", finished, 1);
    @(negedge clk);
    bus_grant = 0; bus_ack = 0; bus_err = 0; bus_tmo = 0; bus_retry = 0; cmd_valid = 0;
    chk(done == 0, "R12 done one cycle", done, 0);
    idle_checks("R2 idle after run");
    @(negedge clk);
    idle_checks("R2 no stray run");
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    idle_checks("R1 during reset");
    chk(rd_valid == 0 && usr_beat == 0 && done == 0, "R1 pulses low", {rd_valid, usr_beat, done}, 0);
    rst = 0;
    @(negedge clk);
    idle_checks("R1 after reset");
    // directed cases
    run(1, 32'h0000_1000, 8'd1, 0, 0, 0, 0, 0);   // single write, R7 no lock
    run(0, 32'h0000_2000, 8'd1, 0, 0, 0, 0, 0);   // single read, R8
    run(1, 32'h0000_3000, 8'd0, 0, 0, 0, 0, 0);   // zero length, R12
    run(0, 32'h0000_4000, 8'd2, 0, 0, 0, 0, 0);   // lock falls after first ack, R7
    run(1, 32'h0000_5000, 8'd5, 0, 0, 0, 1, 0);   // busy poke ignored, R2
    run(0, 32'h0000_6000, 8'd6, 40, 0, 0, 0, 0);  // heavy retry, R10
    run(1, 32'h0000_7000, 8'd4, 0, 100, 0, 0, 0); // error abort, R11
    run(0, 32'h0000_8000, 8'd4, 0, 0, 100, 0, 0); // timeout abort, R11
    run(1, 32'h0000_9000, 8'd3, 0, 0, 0, 0, 1);   // priority error first, R11
    run(0, 32'h0000_A000, 8'd3, 0, 0, 0, 0, 2);   // priority timeout over retry, R11
    // constrained random runs
    for (int k = 0; k < 40; k++) begin
      logic [AW-1:0] a;
      a = $urandom & 32'hFFFF_FFFC;
      run(1'($urandom % 2), a, LW'($urandom % 13), 15, 2, 2, 0, 0);
    end
    ended = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule